// File: doc/BRIEF.md
# Manchester-Coded Sensor Bus Slave

This block is the slave end of a slow, synchronous sensor bus that has one master. The master sends frames on a Manchester-coded data line. The slave recovers the bits from that line using timing taken from its own system clock. It assembles the bits into frames and keeps only the frames that are meant for it and that arrive intact. A frame is meant for it when it carries the node's own address or the all-slaves address. Each kept frame is handed to the local sensor logic as a one-cycle command carrying a code and a byte.

In the other direction, the sensor logic pushes sample words into a small queue. When a unicast read command arrives, the slave first waits out a turnaround gap. It then takes the oldest word from the queue, splits it into byte-sized fragments and sends each fragment back as its own Manchester-coded frame. Commands sent to all slaves are reported locally but are never answered on the bus. A clear command empties the queue whether it is addressed to one slave or to all of them.

Top module: `mbus_slave`

## Requirements
- R1: While reset is held and right after it is released, `bus_dout`, `bus_drive`, `cmd_valid` and `code_err` are 0 and `smp_ready` is 1.
- R2: Bit coding and frame layout, which apply in both directions:
  - One bit lasts 2*HALF_CYC clocks. A 1 is sent high for the first half and low for the second half. A 0 is sent low for the first half and high for the second half.
  - A frame is a start bit of value 1 followed by 24 bits, most significant bit first: address[4:0], command[2:0], data[7:0], sum[7:0].
- R3: A frame whose address equals `node_addr` (range 0 to 30) is accepted. A frame with any other address other than 31 causes no `cmd_valid`.
- R4: Address 31 is the all-slaves address. Such a frame is accepted by every node and is reported with `cmd_bcast`=1. A unicast frame is reported with `cmd_bcast`=0.
- R5: The sum field must equal ({address,command} + data) mod 256. If it does not, the frame is dropped silently and no `cmd_valid` follows.
- R6: If the two halves of a received bit are equal, or the start bit is not 1, the slave raises a one-cycle `code_err` pulse and discards the frame.
- R7: For each accepted frame, `cmd_valid` is high for exactly one cycle, with `cmd_code` and `cmd_data` taken from the frame.
- R8: A unicast frame with command 1 (read) starts a reply only if the queue is not empty. The reply starts after the line has been idle for at least two bit times since the frame ended. A read sent to the all-slaves address, or a read that finds the queue empty, produces no reply.
- R9: A reply sends the oldest sample as SMP_W/8 frames, most significant byte first. Each reply frame has:
  - address = `node_addr`;
  - command field = fragment index (0 for the first fragment);
  - a valid sum.
  Consecutive reply frames are separated by two idle bit times.
- R10: The sample queue holds FIFO_DEPTH words in arrival order. `smp_ready` is 0 exactly when the queue is full, and a sample offered while `smp_ready` is 0 is not stored.
- R11: An accepted frame with command 4 (clear) empties the queue, whether it is unicast or sent to all slaves.
- R12: `bus_drive` is 1 exactly while reply bits are on `bus_dout`. Whenever `bus_drive` is 0, `bus_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit timing is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 5 | Static address of this node (0 to 30) |
| bus_din | input | 1 | Coded data line from the master; idles low |
| bus_dout | output | 1 | Coded reply data |
| bus_drive | output | 1 | High while the slave drives a reply |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| cmd_code | output | 3 | Command field of the accepted frame |
| cmd_bcast | output | 1 | Accepted frame used the all-slaves address |
| cmd_data | output | 8 | Data byte of the accepted frame |
| code_err | output | 1 | One-cycle pulse on a coding violation |
| smp_valid | input | 1 | Sensor offers a sample word |
| smp_data | input | SMP_W | Sample word (default 16 bits) |
| smp_ready | output | 1 | Queue can take a sample |

## Verification
The assertions rely on the master behaving well on the bus:
- The line stays low for at least two bit times between frames.
- The master never transmits while a reply is in progress.
- No sample is offered in the same cycle that a clear command takes effect.
- HALF_CYC is at least 2.

The stimulus keeps to these rules in three ways:
- It leaves three idle bit times after every frame.
- It waits long enough for any reply to finish before sending the next frame.
- It pushes samples only while the line is quiet.

Coding faults are injected as a bit whose two halves are both high. This keeps the low-going runs short enough that the fault cannot look like a new start bit.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W  = 5;
  localparam int CMD_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = ADDR_W + CMD_W + 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] ADDR_ALL  = '1;
  localparam logic [CMD_W-1:0]  CMD_READ  = 3'd1;
  localparam logic [CMD_W-1:0]  CMD_CLEAR = 3'd4;

  // Modulo-256 sum over the header byte and the data byte
  function automatic logic [BYTE_W-1:0] frame_sum(input logic [ADDR_W-1:0] a,
                                                  input logic [CMD_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
    return {a, c} + d;
  endfunction

  function automatic logic [FIELD_W-1:0] pack_fields(input logic [ADDR_W-1:0] a,
                                                     input logic [CMD_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    return {a, c, d, frame_sum(a, c, d)};
  endfunction
endpackage

// File: rtl/mbus_rx.sv
module mbus_rx
  import mbus_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  output logic               frame_done,
  output logic [FIELD_W-1:0] frame_bits,
  output logic               code_err
);
  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int QUIET   = 3 * HALF_CYC;
  localparam int NBITS   = FIELD_W + 1;
  localparam int CW      = $clog2(QUIET + 1);
  localparam int BW      = $clog2(NBITS + 1);
  localparam logic [CW-1:0] P_FIRST = CW'(HALF_CYC / 2);
  localparam logic [CW-1:0] P_SEC   = CW'(HALF_CYC + HALF_CYC / 2);
  localparam logic [CW-1:0] P_LAST  = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] Q_FULL  = CW'(QUIET);
  localparam logic [BW-1:0] B_LAST  = BW'(NBITS - 1);

  logic [1:0]         sync;
  logic               ln, ln_d;
  logic [CW-1:0]      qcnt;
  logic               busy;
  logic [CW-1:0]      pos;
  logic [BW-1:0]      bidx;
  logic               h1;
  logic [FIELD_W-1:0] sh;
  logic               quiet, rise;

  assign ln    = sync[1];
  assign quiet = (qcnt == Q_FULL);
  assign rise  = ln && !ln_d && quiet;
  assign frame_bits = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0;
      ln_d <= 1'b0;
      qcnt <= '0;
    end else begin
      sync <= {sync[0], line_in};
      ln_d <= ln;
      if (ln) qcnt <= '0;
      else if (!quiet) qcnt <= qcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pos        <= '0;
      bidx       <= '0;
      h1         <= 1'b0;
      sh         <= '0;
      frame_done <= 1'b0;
      code_err   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      code_err   <= 1'b0;
      if (!busy) begin
        if (rise) begin
          busy <= 1'b1;
          pos  <= CW'(1);
          bidx <= '0;
        end
      end else begin
        pos <= (pos == P_LAST) ? '0 : pos + CW'(1);
        if (pos == P_FIRST) h1 <= ln;
        if (pos == P_SEC) begin
          if ((ln == h1) || (bidx == '0 && !h1)) begin
            code_err <= 1'b1;
            busy     <= 1'b0;
          end else if (bidx != '0) begin
            sh <= {sh[FIELD_W-2:0], h1};
          end
        end
        if (pos == P_LAST) begin
          if (bidx == B_LAST) begin
            frame_done <= 1'b1;
            busy       <= 1'b0;
          end else begin
            bidx <= bidx + BW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbus_fifo.sv
module mbus_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == A_LAST) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == C_FULL);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/mbus_tx.sv
module mbus_tx
  import mbus_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int SMP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SMP_W-1:0]  word,
  input  logic [ADDR_W-1:0] node_addr,
  output logic              line_out,
  output logic              drive,
  output logic              busy
);
  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int GAP_CYC = 2 * BIT_CYC;
  localparam int NBITS   = FIELD_W + 1;
  localparam int NFRAG   = SMP_W / BYTE_W;
  localparam int CW      = $clog2(GAP_CYC + 1);
  localparam int BW      = $clog2(NBITS + 1);
  localparam int FW      = (NFRAG > 1) ? $clog2(NFRAG) : 1;
  localparam logic [CW-1:0] C_HALF = CW'(HALF_CYC);
  localparam logic [CW-1:0] C_BIT  = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] C_GAP  = CW'(GAP_CYC - 1);
  localparam logic [BW-1:0] B_LAST = BW'(NBITS - 1);
  localparam logic [FW-1:0] F_LAST = FW'(NFRAG - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_GAP, TX_SEND} tx_state_t;

  tx_state_t        st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [FW-1:0]    frag;
  logic [SMP_W-1:0] word_q, shifted;
  logic [FIELD_W:0] sh;
  logic [BYTE_W-1:0] frag_byte;

  always_comb begin
    shifted   = word_q << (BYTE_W * frag);
    frag_byte = shifted[SMP_W-1 -: BYTE_W];
  end

  assign busy     = (st != TX_IDLE);
  assign drive    = (st == TX_SEND);
  assign line_out = drive && ((cnt < C_HALF) ? sh[FIELD_W] : !sh[FIELD_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      frag   <= '0;
      word_q <= '0;
      sh     <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          st     <= TX_GAP;
          cnt    <= '0;
          frag   <= '0;
          word_q <= word;
        end
        TX_GAP: begin
          if (cnt == C_GAP) begin
            st   <= TX_SEND;
            cnt  <= '0;
            bidx <= '0;
            sh   <= {1'b1, pack_fields(node_addr, CMD_W'(frag), frag_byte)};
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        TX_SEND: begin
          if (cnt == C_BIT) begin
            cnt <= '0;
            if (bidx == B_LAST) begin
              if (frag == F_LAST) begin
                st <= TX_IDLE;
              end else begin
                frag <= frag + FW'(1);
                st   <= TX_GAP;
              end
            end else begin
              bidx <= bidx + BW'(1);
              sh   <= {sh[FIELD_W-1:0], 1'b0};
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int SMP_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              bus_din,
  output logic              bus_dout,
  output logic              bus_drive,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_bcast,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              code_err,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              smp_ready
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic               frame_done;
  logic [FIELD_W-1:0] frame_bits;
  logic [ADDR_W-1:0]  f_addr;
  logic [CMD_W-1:0]   f_cmd;
  logic [BYTE_W-1:0]  f_data, f_sum;
  logic               is_all, addr_hit, sum_ok, accept;
  logic               tx_start, tx_busy, fifo_flush;
  logic               fifo_full, fifo_empty;
  logic [SMP_W-1:0]   fifo_head;
  logic [CNT_W-1:0]   fifo_cnt;

  mbus_rx #(.HALF_CYC(HALF_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_in(bus_din),
    .frame_done(frame_done), .frame_bits(frame_bits), .code_err(code_err)
  );

  assign {f_addr, f_cmd, f_data, f_sum} = frame_bits;
  assign is_all     = (f_addr == ADDR_ALL);
  assign addr_hit   = is_all || (f_addr == node_addr);
  assign sum_ok     = (f_sum == frame_sum(f_addr, f_cmd, f_data));
  assign accept     = frame_done && addr_hit && sum_ok;
  assign fifo_flush = accept && (f_cmd == CMD_CLEAR);
  assign tx_start   = accept && !is_all && (f_cmd == CMD_READ) && !fifo_empty && !tx_busy;

  mbus_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(smp_valid), .wdata(smp_data),
    .pop(tx_start), .flush(fifo_flush), .rdata(fifo_head),
    .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  assign smp_ready = !fifo_full;

  mbus_tx #(.HALF_CYC(HALF_CYC), .SMP_W(SMP_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .word(fifo_head),
    .node_addr(node_addr), .line_out(bus_dout), .drive(bus_drive), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_bcast <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_code  <= f_cmd;
        cmd_bcast <= is_all;
        cmd_data  <= f_data;
      end
    end
  end
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk #(
  parameter int HALF_CYC   = 4,
  parameter int FIFO_DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_dout,
  input logic                           bus_drive,
  input logic                           cmd_valid,
  input logic                           cmd_bcast,
  input logic                           code_err,
  input logic                           frame_done,
  input logic                           tx_start,
  input logic                           fifo_flush,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
  input logic                           smp_valid,
  input logic                           smp_ready
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int GAP   = 4 * HALF_CYC;
  localparam int GW    = $clog2(GAP + 1);
  localparam logic [GW-1:0] G_FULL = GW'(GAP);

  // cycles since the last received frame or the last driven reply cycle
  logic [GW-1:0] gcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) gcnt <= G_FULL;
    else if (frame_done || bus_drive) gcnt <= '0;
    else if (gcnt != G_FULL) gcnt <= gcnt + GW'(1);
  end

  p_quiet_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> !bus_dout);

  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_err_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> !cmd_valid);

  p_bcast_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bcast) |-> !$past(tx_start));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> (gcnt == G_FULL));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  p_push_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !tx_start && !fifo_flush)
      |=> (fifo_cnt == $past(fifo_cnt) + CNT_W'(1)));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (fifo_cnt == '0));
endmodule

bind mbus_slave mbus_slave_chk #(.HALF_CYC(HALF_CYC), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_dout(bus_dout), .bus_drive(bus_drive),
  .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .code_err(code_err),
  .frame_done(frame_done), .tx_start(tx_start), .fifo_flush(fifo_flush),
  .fifo_cnt(fifo_cnt), .smp_valid(smp_valid), .smp_ready(smp_ready)
);

// File: tb/mbus_slave_tb.sv
module mbus_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H    = 4;
  localparam int BITC = 2 * H;
  localparam logic [4:0] NODE = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_din = 1'b0;
  logic        bus_dout, bus_drive, cmd_valid, cmd_bcast, code_err, smp_ready;
  logic [2:0]  cmd_code;
  logic [7:0]  cmd_data;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_err = 0, n_rep = 0, n_viol = 0;
  logic [11:0] exp_cmd[$];
  logic [23:0] exp_rep[$];
  logic [15:0] mfifo[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_slave #(.HALF_CYC(H), .SMP_W(16), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_addr(NODE), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_drive(bus_drive), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bcast(cmd_bcast), .cmd_data(cmd_data),
    .code_err(code_err), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sum_of(input logic [4:0] a, input logic [2:0] c,
                                        input logic [7:0] d);
    int s;
    s = (int'(a) * 8 + int'(c) + int'(d)) % 256;
    return s[7:0];
  endfunction

  task automatic send_bit(input logic b, input bit broken);
    bus_din = broken ? 1'b1 : b;
    repeat (H) @(negedge clk);
    bus_din = broken ? 1'b1 : ~b;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_raw(input logic [4:0] a, input logic [2:0] c, input logic [7:0] d,
                          input logic [7:0] s, input int broken_at);
    logic [23:0] f;
    f = {a, c, d, s};
    send_bit(1'b1, 1'b0);
    for (int i = 23; i >= 0; i--) send_bit(f[i], (23 - i) == broken_at);
    bus_din = 1'b0;
    repeat (3 * BITC) @(negedge clk);
  endtask

  // driver: sends a frame and updates the expected model
  task automatic drive_frame(input logic [4:0] a, input logic [2:0] c, input logic [7:0] d,
                             input bit good_sum);
    logic [7:0] s;
    logic [15:0] w;
    s = good_sum ? sum_of(a, c, d) : sum_of(a, c, d) ^ 8'h01;
    if (good_sum && (a == NODE || a == 5'd31)) begin
      exp_cmd.push_back({(a == 5'd31), c, d});
      if (c == 3'd4) mfifo.delete();
      if (c == 3'd1 && a == NODE && mfifo.size() > 0) begin
        w = mfifo.pop_front();
        exp_rep.push_back({NODE, 3'd0, w[15:8], sum_of(NODE, 3'd0, w[15:8])});
        exp_rep.push_back({NODE, 3'd1, w[7:0], sum_of(NODE, 3'd1, w[7:0])});
      end
    end
    send_raw(a, c, d, s, -1);
    if (c == 3'd1) repeat (600) @(negedge clk);
  endtask

  task automatic push_sample(input logic [15:0] d);
    smp_valid = 1'b1;
    smp_data  = d;
    if (smp_ready) mfifo.push_back(d);
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: command strobes
  always @(negedge clk) begin
    logic [11:0] e;
    if (rst_n && cmd_valid) begin
      n_cmd++;
      if (exp_cmd.size() == 0) begin
        check(1'b0, "R7", "unexpected cmd_valid", {cmd_bcast, cmd_code, cmd_data}, 0);
      end else begin
        e = exp_cmd.pop_front();
        check({cmd_bcast, cmd_code, cmd_data} == e, "R7/R4",
              "command fields", {cmd_bcast, cmd_code, cmd_data}, e);
      end
    end
    if (rst_n && code_err) n_err++;
    if (rst_n && !bus_drive && bus_dout) n_viol++;
  end

  // monitor: reply frames
  initial begin
    int lowc;
    int bad_code;
    logic a, b;
    logic [24:0] fr;
    logic [23:0] e;
    lowc = 1000;
    forever begin
      @(negedge clk);
      if (!bus_drive) begin
        lowc++;
      end else begin
        check(lowc >= 4 * H - 1, "R9", "idle gap before reply frame", lowc, 4 * H - 1);
        bad_code = 0;
        for (int i = 24; i >= 0; i--) begin
          a = bus_dout;
          if (!bus_drive) bad_code++;
          repeat (H) @(negedge clk);
          b = bus_dout;
          if (!bus_drive || a == b) bad_code++;
          fr[i] = a;
          repeat (H) @(negedge clk);
        end
        n_rep++;
        check(bad_code == 0, "R2", "reply half-bit coding errors", bad_code, 0);
        check(fr[24] == 1'b1, "R2", "reply start bit", fr[24], 1);
        if (exp_rep.size() == 0) begin
          check(1'b0, "R8", "unexpected reply frame", fr[23:0], 0);
        end else begin
          e = exp_rep.pop_front();
          check(fr[23:0] == e, "R9", "reply frame fields", fr[23:0], e);
        end
        lowc = 0;
      end
    end
  end

  initial begin
    int c0, r0;
    repeat (5) @(negedge clk);
    check(bus_dout == 1'b0, "R1", "bus_dout in reset", bus_dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_drive == 1'b0, "R1", "bus_drive after reset", bus_drive, 0);
    check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    check(code_err == 1'b0, "R1", "code_err after reset", code_err, 0);
    check(smp_ready == 1'b1, "R1", "smp_ready after reset", smp_ready, 1);
    repeat (4 * BITC) @(negedge clk);

    // R3/R7: unicast command to own address
    drive_frame(NODE, 3'd3, 8'h5A, 1'b1);
    check(n_cmd == 1, "R3", "own-address frame accepted", n_cmd, 1);
    drive_frame(NODE, 3'd6, 8'h00, 1'b1);
    drive_frame(NODE, 3'd2, 8'hFF, 1'b1);

    // R3: other address ignored
    c0 = n_cmd;
    drive_frame(5'd4, 3'd3, 8'h77, 1'b1);
    drive_frame(5'd30, 3'd5, 8'h12, 1'b1);
    check(n_cmd == c0, "R3", "foreign-address frames ignored", n_cmd, c0);

    // R4: all-slaves frame
    drive_frame(5'd31, 3'd5, 8'h11, 1'b1);
    check(n_cmd == c0 + 1, "R4", "all-slaves frame accepted", n_cmd, c0 + 1);

    // R5: bad sum dropped
    c0 = n_cmd;
    drive_frame(NODE, 3'd3, 8'hC3, 1'b0);
    check(n_cmd == c0, "R5", "bad-sum frame dropped", n_cmd, c0);

    // R6: coding violation in the data field
    c0 = n_cmd;
    send_raw(NODE, 3'd3, 8'hF0, sum_of(NODE, 3'd3, 8'hF0), 10);
    check(n_err == 1, "R6", "code_err pulse count", n_err, 1);
    check(n_cmd == c0, "R6", "broken frame discarded", n_cmd, c0);

    // R8/R9: read with queued samples
    push_sample(16'hA1B2);
    push_sample(16'h3C4D);
    push_sample(16'h0102);
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    check(n_rep == 2, "R8", "read produced fragment frames", n_rep, 2);

    // R8: read sent to all slaves has no reply
    r0 = n_rep;
    drive_frame(5'd31, 3'd1, 8'h00, 1'b1);
    check(n_rep == r0, "R8", "all-slaves read silent", n_rep, r0);

    // R10: fill queue (two held) and offer one too many
    push_sample(16'h5566);
    push_sample(16'h7788);
    check(smp_ready == 1'b0, "R10", "smp_ready when full", smp_ready, 0);
    push_sample(16'hDEAD);
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    check(smp_ready == 1'b1, "R10", "smp_ready after pop", smp_ready, 1);
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);

    // R11: clear sent to all slaves
    drive_frame(5'd31, 3'd4, 8'h00, 1'b1);
    r0 = n_rep;
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    check(n_rep == r0, "R11", "no reply after all-slaves clear", n_rep, r0);

    // R11: unicast clear
    push_sample(16'hBEEF);
    drive_frame(NODE, 3'd4, 8'h00, 1'b1);
    r0 = n_rep;
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    check(n_rep == r0, "R11", "no reply after unicast clear", n_rep, r0);

    // R8: read on an empty queue after refill and drain
    push_sample(16'h1234);
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    r0 = n_rep;
    drive_frame(NODE, 3'd1, 8'h00, 1'b1);
    check(n_rep == r0, "R8", "empty-queue read silent", n_rep, r0);

    check(n_viol == 0, "R12", "dout high while not driving", n_viol, 0);
    check(exp_cmd.size() == 0, "R7", "commands still expected", exp_cmd.size(), 0);
    check(exp_rep.size() == 0, "R9", "reply frames still expected", exp_rep.size(), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule